// File: doc/BRIEF.md
# Latched 8-to-1 Multiplexer With Tri-State Outputs

This block picks one bit out of eight and presents it on a pair of complementary outputs. The eight data inputs and the three select inputs each pass through their own level-sensitive latch before the selection. Each latch is open (transparent) while its active-low control is low. It keeps its contents once that control goes high.

The stored select value picks one stored data bit. That bit appears unchanged on the true output and inverted on the complement output. Three enables (two active low, one active high) jointly decide whether the outputs drive. High impedance is modelled as a separate drive-enable signal beside each data output. An enclosing level can turn each pair into a tri-state wire. The latches keep working while the outputs are not driving. Nothing is reset: the contents of both latches are undefined until each has been opened once.

Top module: `latched_sel8`

## Requirements
- R1: While `data_open_n_i` is low, the data latch is transparent, and the outputs follow changes on `data_i` with no clock.
- R2: When `data_open_n_i` rises, the data latch keeps the value `data_i` had at that moment. While it stays high, changes on `data_i` do not change `true_o` or `inv_o`.
- R3: While `addr_open_n_i` is low, the address latch is transparent, and the outputs follow changes on `addr_i`.
- R4: When `addr_open_n_i` rises, the address latch keeps the select value. While it stays high, changes on `addr_i` do not change `true_o` or `inv_o`.
- R5: A stored address k (binary, 0 to 7) selects stored data bit k: address 0 picks `data_i[0]` and address 7 picks `data_i[7]`.
- R6: `true_o` equals the selected bit, and `inv_o` equals its complement.
- R7: `true_en_o` and `inv_en_o` are both 1 (driving) exactly when `en_a_n_i`=0, `en_b_n_i`=0 and `en_c_i`=1. For all seven other enable combinations both are 0 (high impedance).
- R8: While the outputs are disabled, both latches still load and hold. Enabling the outputs again shows the selection stored at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Data inputs to the data latch |
| data_open_n_i | input | 1 | Data latch control; low = transparent, high = hold |
| addr_i | input | 3 | Select inputs to the address latch |
| addr_open_n_i | input | 1 | Address latch control; low = transparent, high = hold |
| en_a_n_i | input | 1 | Output enable, active low |
| en_b_n_i | input | 1 | Output enable, active low |
| en_c_i | input | 1 | Output enable, active high |
| true_o | output | 1 | Selected bit, non-inverted |
| true_en_o | output | 1 | 1 = `true_o` drives, 0 = high impedance |
| inv_o | output | 1 | Selected bit, inverted |
| inv_en_o | output | 1 | 1 = `inv_o` drives, 0 = high impedance |

## Verification
The hardest case to reach is a latch that holds while its own inputs move and the other latch stays open. This is the only case that separates a held value from a live one. The stimulus therefore closes one latch, moves that latch's inputs to values that would flip the output, and then changes the other latch's inputs. In every case the inputs change only while the relevant control is stable. Loading fresh data and a fresh address while the outputs are disabled, then enabling them, shows that the latches never depended on the enables.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

  // Number of data channels and the width of the address that selects one.
  localparam int unsigned LSEL_CH = 8;
  localparam int unsigned LSEL_AW = $clog2(LSEL_CH);

  // The three-input drive condition: both active-low enables low and the
  // active-high enable high.
  function automatic logic drive_allowed(input logic a_n, input logic b_n,
                                         input logic c);
    return ~(a_n | b_n | ~c);
  endfunction

endpackage

// File: rtl/lsel_latch.sv
module lsel_latch #(
  parameter int unsigned W = 8
) (
  input  logic         open_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Level-sensitive storage: transparent while open_n is low.
  always_latch begin
    if (!open_n) q = d;
  end

  // R1 R3
  always_comb begin
    if (!open_n) begin
      transparent_chk: assert (q == d)
        else $error("latch not transparent while open");
    end
  end

endmodule

// File: rtl/lsel_pick.sv
module lsel_pick #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] bits,
  input  logic [AW-1:0]  addr,
  output logic           pick_true,
  output logic           pick_comp
);

  logic [NCH-1:0] hot;

  // One-hot decode of the stored address.
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign hot[g] = (addr == AW'(g));
  end

  // The true and complement paths are built separately, each as an AND-OR tree.
  assign pick_true = |(bits & hot);
  assign pick_comp = |(~bits & hot);

  // R5
  always_comb begin
    dec_onehot_chk: assert ($onehot0(hot))
      else $error("address decode not one-hot");
  end

  // R5
  always_comb begin
    if (int'(addr) < NCH) begin
      pick_index_chk: assert (pick_true == bits[addr])
        else $error("selected bit does not match address");
    end
  end

  // R6
  always_comb begin
    if (int'(addr) < NCH) begin
      comp_path_chk: assert (pick_comp != pick_true)
        else $error("complement path equals true path");
    end
  end

endmodule

// File: rtl/lsel_drive.sv
module lsel_drive
  import lsel_pkg::*;
(
  input  logic en_a_n,
  input  logic en_b_n,
  input  logic en_c,
  input  logic pick_true,
  input  logic pick_comp,
  output logic true_o,
  output logic true_en_o,
  output logic inv_o,
  output logic inv_en_o
);

  logic drive;

  assign drive     = drive_allowed(en_a_n, en_b_n, en_c);
  assign true_o    = pick_true;
  assign inv_o     = pick_comp;
  assign true_en_o = drive;
  assign inv_en_o  = drive;

  // R7
  always_comb begin
    if (en_a_n || en_b_n || !en_c) begin
      off_when_any_chk: assert (!true_en_o && !inv_en_o)
        else $error("outputs driven with an enable inactive");
    end
  end

  // R7
  always_comb begin
    if (!en_a_n && !en_b_n && en_c) begin
      on_when_all_chk: assert (true_en_o && inv_en_o)
        else $error("outputs not driven with all enables active");
    end
  end

endmodule

// File: rtl/latched_sel8.sv
module latched_sel8
  import lsel_pkg::*;
(
  input  logic [LSEL_CH-1:0] data_i,
  input  logic               data_open_n_i,
  input  logic [LSEL_AW-1:0] addr_i,
  input  logic               addr_open_n_i,
  input  logic               en_a_n_i,
  input  logic               en_b_n_i,
  input  logic               en_c_i,
  output logic               true_o,
  output logic               true_en_o,
  output logic               inv_o,
  output logic               inv_en_o
);

  logic [LSEL_CH-1:0] data_q;
  logic [LSEL_AW-1:0] addr_q;
  logic               pick_true;
  logic               pick_comp;

  lsel_latch #(.W(LSEL_CH)) u_data_lat (
    .open_n (data_open_n_i),
    .d      (data_i),
    .q      (data_q)
  );

  lsel_latch #(.W(LSEL_AW)) u_addr_lat (
    .open_n (addr_open_n_i),
    .d      (addr_i),
    .q      (addr_q)
  );

  lsel_pick #(.NCH(LSEL_CH), .AW(LSEL_AW)) u_pick (
    .bits      (data_q),
    .addr      (addr_q),
    .pick_true (pick_true),
    .pick_comp (pick_comp)
  );

  lsel_drive u_drive (
    .en_a_n    (en_a_n_i),
    .en_b_n    (en_b_n_i),
    .en_c      (en_c_i),
    .pick_true (pick_true),
    .pick_comp (pick_comp),
    .true_o    (true_o),
    .true_en_o (true_en_o),
    .inv_o     (inv_o),
    .inv_en_o  (inv_en_o)
  );

  // R6 R7
  always_comb begin
    if (true_en_o) begin
      pair_opposite_chk: assert (inv_en_o && (inv_o == ~true_o))
        else $error("driven outputs not complementary");
    end
  end

endmodule

// File: tb/tb_latched_sel8.sv
module tb_latched_sel8;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [7:0] data;
  logic       data_open_n;
  logic [2:0] addr;
  logic       addr_open_n;
  logic       en_a_n, en_b_n, en_c;
  logic       t_o, t_en, i_o, i_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_sel8 dut (
    .data_i        (data),
    .data_open_n_i (data_open_n),
    .addr_i        (addr),
    .addr_open_n_i (addr_open_n),
    .en_a_n_i      (en_a_n),
    .en_b_n_i      (en_b_n),
    .en_c_i        (en_c),
    .true_o        (t_o),
    .true_en_o     (t_en),
    .inv_o         (i_o),
    .inv_en_o      (i_en)
  );

  // Vector: {address, data, expected selected bit}
  typedef struct packed {
    logic [2:0] a;
    logic [7:0] d;
    logic       e;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 8'h01, 1'b1},
    '{3'd1, 8'hFD, 1'b0},
    '{3'd2, 8'h04, 1'b1},
    '{3'd3, 8'hF7, 1'b0},
    '{3'd4, 8'h10, 1'b1},
    '{3'd5, 8'hDF, 1'b0},
    '{3'd6, 8'h40, 1'b1},
    '{3'd7, 8'h7F, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, t_o, exp);
    chk(req, i_o, ~exp);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    data = 8'h00; addr = 3'd0;
    data_open_n = 1'b1; addr_open_n = 1'b1;
    en_a_n = 1'b1; en_b_n = 1'b1; en_c = 1'b0;

    // Initial state: outputs disabled before anything is loaded (R7)
    settle();
    chk("R7 initial disabled", t_en, 1'b0);
    chk("R7 initial disabled", i_en, 1'b0);

    // Load both latches, then enable
    step();
    data_open_n = 1'b0; addr_open_n = 1'b0;
    en_a_n = 1'b0; en_b_n = 1'b0; en_c = 1'b1;
    settle();
    chk("R7 enabled", t_en, 1'b1);

    // Table walk: transparent, then held against moving inputs
    foreach (VECS[k]) begin
      step();
      data_open_n = 1'b0; addr_open_n = 1'b0;
      data = VECS[k].d; addr = VECS[k].a;
      settle();
      chk_out("R1 R3 R5 R6 transparent", VECS[k].e);
      step();
      data_open_n = 1'b1; addr_open_n = 1'b1;
      step();
      data = ~VECS[k].d; addr = ~VECS[k].a;
      settle();
      chk_out("R2 R4 R5 held", VECS[k].e);
    end

    // R1: live data follow with the address held at 5
    step();
    addr_open_n = 1'b0; data_open_n = 1'b0; addr = 3'd5; data = 8'h00;
    step();
    addr_open_n = 1'b1;
    step();
    data = 8'h20;
    settle();
    chk_out("R1 follows live data", 1'b1);
    step();
    data = 8'hDF;
    settle();
    chk_out("R1 follows live data", 1'b0);

    // R2: data closed at 8'h20, address open and moving
    step();
    data = 8'h20;
    step();
    data_open_n = 1'b1;
    step();
    data = 8'hDF;
    addr_open_n = 1'b0;
    settle();
    chk_out("R2 data held bit5", 1'b1);
    step();
    addr = 3'd2;
    settle();
    chk_out("R2 R3 data held bit2", 1'b0);

    // R4: address closed at 2, data open and moving
    step();
    addr_open_n = 1'b1;
    step();
    addr = 3'd6;
    data_open_n = 1'b0;
    data = 8'h04;
    settle();
    chk_out("R4 addr held at 2", 1'b1);
    step();
    data = 8'h40;
    settle();
    chk_out("R4 addr held at 2", 1'b0);

    // R7: every enable combination (bit2=a_n, bit1=b_n, bit0=c)
    for (int e = 0; e < 8; e++) begin
      step();
      en_a_n = e[2]; en_b_n = e[1]; en_c = e[0];
      settle();
      chk("R7 enable combo true", t_en, (e == 1));
      chk("R7 enable combo inv", i_en, (e == 1));
    end

    // R8: disabled, load new address 3 and data 8'h08, then enable again
    step();
    en_a_n = 1'b1; en_b_n = 1'b0; en_c = 1'b1;
    addr_open_n = 1'b0; data_open_n = 1'b0;
    addr = 3'd3; data = 8'h08;
    step();
    addr_open_n = 1'b1; data_open_n = 1'b1;
    step();
    addr = 3'd0; data = 8'h00;
    en_a_n = 1'b0;
    settle();
    chk("R8 re-enabled", t_en, 1'b1);
    chk_out("R8 stored selection", 1'b1);

    step();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule